// File: doc/BRIEF.md
# Channel Status Readout Register

This block gathers the 32 consumer-format channel-status bits that a digital audio receiver recovers one per frame, and hands them to a host controller over a slow serial readout port. Capture runs only while the receiver reports lock. A block is accepted once all of its frames, from the block-start marker to the last frame, have arrived. The first 32 frames' bits are then copied into a holding register and a valid output goes high.

The host reads the register by raising its select input and pulling the latch strobe low. The block answers with a marker bit that is always high. The host then pulses its shift clock and gets the 32 stored bits, the earliest received bit first, one per rising edge. After the last bit the line returns low. When the error input is high and the lock input is low at the same time, the shift and holding registers are wiped to zero. An error with lock still held, such as a parity fault, is ignored. Readouts must be spaced by a minimum interval, given in system clocks. A strobe that comes too early raises a one-cycle violation pulse, but the readout still takes place.

All host inputs are taken to be synchronous to `clk`. They are sampled on its rising edge, and edges are found by comparing each sample with the one before.

Top module: `cs_status_readout`

## Requirements
- R1: After reset, `sdo`, `valid` and `violation` are all low.
- R2: While `rx_locked` is high, each `frame_stb` cycle stores `cs_bit`. When `blk_start` is high it sets frame index 0, and each following strobe counts up by one. The bit of frame k (k < 32) becomes held bit k. `valid` rises one cycle after the strobe of frame FRAMES-1, and the new bits replace the old ones at that moment.
- R3: Frames that arrive while `rx_locked` is low are not stored. A lock drop in the middle of a block abandons that block, so `valid` stays low and the held data stays as it was.
- R4: A cycle in which `sel` is high and `latch_n` has fallen from high to low starts a readout. In the next cycle `sdo` is 1, the marker bit.
- R5: After the n-th rising edge of `sclk` following a readout start (n = 1..32), `sdo` in the next cycle carries held bit n-1.
- R6: From the 33rd rising edge of `sclk` on, `sdo` is low until the next readout start.
- R7: A falling edge of `latch_n` while `sel` is low starts nothing: `sdo` and `violation` stay unchanged.
- R8: A cycle with `rx_error` high and `rx_locked` low clears the register. The next cycle `sdo` and `valid` are low, and the remaining shifts output 0. A later readout shows the marker followed by 32 zeros.
- R9: `rx_error` high while `rx_locked` is high changes neither `sdo`, the rest of the bit stream, nor `valid`.
- R10: If a readout start comes GAP_CYCLES clock cycles or fewer after the previous one, `violation` is high for exactly the following cycle. A start that comes later, or the first start after reset, leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_locked | input | 1 | Receiver lock indication |
| rx_error | input | 1 | Receiver error (lock loss or parity) |
| frame_stb | input | 1 | One cycle per received frame |
| blk_start | input | 1 | Marks frame 0 of a block, valid with `frame_stb` |
| cs_bit | input | 1 | Channel-status bit of the current frame |
| sel | input | 1 | Host readout address selects this register |
| latch_n | input | 1 | Host latch strobe, a falling edge starts a readout |
| sclk | input | 1 | Host shift clock, rising edge advances one bit |
| sdo | output | 1 | Serial readout data |
| valid | output | 1 | A complete block is held |
| violation | output | 1 | One-cycle pulse: readout started too soon |

## Verification
Every output is one register stage away from the input sample that causes it. A strobe, shift edge or clear seen at rising edge t is therefore visible from edge t onward. Valid rises the cycle after the strobe of the final frame. The bench drives inputs on the falling edge and advances one rising edge per step. It compares outputs at the falling edge that follows, so each result is read in the first cycle it is due. The bench does not sample later, so a design that is one cycle late fails.

// File: rtl/cs_readout_pkg.sv
package cs_readout_pkg;
    localparam int  CS_BITS_DEF    = 32;
    localparam int  FRAMES_DEF     = 192;
    localparam int  GAP_CYCLES_DEF = 1_200_000;
    localparam logic MARKER_LEVEL  = 1'b1;
endpackage

// File: rtl/csr_capture.sv
module csr_capture #(
    parameter int CS_BITS = 32,
    parameter int FRAMES  = 192
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               locked,
    input  logic               frame_stb,
    input  logic               blk_start,
    input  logic               cs_bit,
    output logic [CS_BITS-1:0] hold,
    output logic               valid
);
    localparam int IDX_W = $clog2(FRAMES);
    localparam int BIT_W = $clog2(CS_BITS);

    typedef struct packed {
        logic [CS_BITS-1:0] cap;
        logic [CS_BITS-1:0] hold;
        logic [IDX_W-1:0]   idx;
        logic               in_blk;
        logic               valid;
    } cap_t;

    cap_t cap_q, cap_d;

    always_comb begin
        cap_d = cap_q;
        if (clr) begin
            cap_d = '0;
        end else if (!locked) begin
            cap_d.in_blk = 1'b0;
            cap_d.idx    = '0;
        end else if (frame_stb) begin
            if (blk_start) begin
                cap_d.cap    = '0;
                cap_d.cap[0] = cs_bit;
                cap_d.idx    = IDX_W'(1);
                cap_d.in_blk = 1'b1;
            end else if (cap_q.in_blk) begin
                if (cap_q.idx < IDX_W'(CS_BITS)) begin
                    cap_d.cap[cap_q.idx[BIT_W-1:0]] = cs_bit;
                end
                if (cap_q.idx == IDX_W'(FRAMES - 1)) begin
                    cap_d.hold   = cap_q.cap;
                    cap_d.valid  = 1'b1;
                    cap_d.in_blk = 1'b0;
                    cap_d.idx    = '0;
                end else begin
                    cap_d.idx = cap_q.idx + IDX_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign hold  = cap_q.hold;
    assign valid = cap_q.valid;
endmodule

// File: rtl/csr_shifter.sv
module csr_shifter
    import cs_readout_pkg::*;
#(
    parameter int CS_BITS = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               load,
    input  logic               shift,
    input  logic [CS_BITS-1:0] data,
    output logic               sdo
);
    typedef struct packed {
        logic [CS_BITS:0] sh;
    } sh_t;

    sh_t sh_q, sh_d;

    always_comb begin
        sh_d = sh_q;
        if (clr) begin
            sh_d.sh = '0;
        end else if (load) begin
            sh_d.sh = {data, MARKER_LEVEL};
        end else if (shift) begin
            sh_d.sh = {1'b0, sh_q.sh[CS_BITS:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sdo = sh_q.sh[0];
endmodule

// File: rtl/csr_gap_timer.sv
module csr_gap_timer #(
    parameter int GAP_CYCLES = 1_200_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic violation
);
    localparam int CNT_W = $clog2(GAP_CYCLES + 1);
    localparam logic [CNT_W-1:0] GAP_MAX = CNT_W'(GAP_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             viol;
    } gap_t;

    gap_t gap_q, gap_d;

    always_comb begin
        gap_d      = gap_q;
        gap_d.viol = 1'b0;
        if (start) begin
            gap_d.viol = (gap_q.cnt < GAP_MAX);
            gap_d.cnt  = '0;
        end else if (gap_q.cnt < GAP_MAX) begin
            gap_d.cnt = gap_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q.cnt  <= GAP_MAX;
            gap_q.viol <= 1'b0;
        end else begin
            gap_q <= gap_d;
        end
    end

    assign violation = gap_q.viol;
endmodule

// File: rtl/cs_status_readout.sv
module cs_status_readout
    import cs_readout_pkg::*;
#(
    parameter int CS_BITS    = CS_BITS_DEF,
    parameter int FRAMES     = FRAMES_DEF,
    parameter int GAP_CYCLES = GAP_CYCLES_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_locked,
    input  logic rx_error,
    input  logic frame_stb,
    input  logic blk_start,
    input  logic cs_bit,
    input  logic sel,
    input  logic latch_n,
    input  logic sclk,
    output logic sdo,
    output logic valid,
    output logic violation
);
    typedef struct packed {
        logic latch_q;
        logic sclk_q;
    } edge_t;

    edge_t edge_q, edge_d;

    logic               clr;
    logic               rd_start;
    logic               rd_shift;
    logic [CS_BITS-1:0] held;

    always_comb begin
        edge_d.latch_q = latch_n;
        edge_d.sclk_q  = sclk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q.latch_q <= 1'b1;
            edge_q.sclk_q  <= 1'b0;
        end else begin
            edge_q <= edge_d;
        end
    end

    assign clr      = rx_error & ~rx_locked;
    assign rd_start = sel & edge_q.latch_q & ~latch_n;
    assign rd_shift = sclk & ~edge_q.sclk_q;

    csr_capture #(.CS_BITS(CS_BITS), .FRAMES(FRAMES)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .locked    (rx_locked),
        .frame_stb (frame_stb),
        .blk_start (blk_start),
        .cs_bit    (cs_bit),
        .hold      (held),
        .valid     (valid)
    );

    csr_shifter #(.CS_BITS(CS_BITS)) u_shifter (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .load  (rd_start),
        .shift (rd_shift),
        .data  (held),
        .sdo   (sdo)
    );

    csr_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (rd_start),
        .violation (violation)
    );
endmodule

// File: rtl/cs_status_readout_chk.sv
module cs_status_readout_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_locked,
    input logic rx_error,
    input logic sel,
    input logic latch_n,
    input logic sclk,
    input logic sdo,
    input logic valid,
    input logic violation
);
    p_marker_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && $fell(latch_n) && !(rx_error && !rx_locked)) |=> sdo);

    p_clear_zeroes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_error && !rx_locked) |=> (!sdo && !valid));

    p_valid_drop_only_on_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid) |-> $past(rx_error && !rx_locked));

    p_sdo_holds_without_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(sclk) && $stable(latch_n) && !(rx_error && !rx_locked)) |=> $stable(sdo));

    p_violation_needs_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> $past(sel && !latch_n));

    p_violation_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> !violation);
endmodule

bind cs_status_readout cs_status_readout_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_locked (rx_locked),
    .rx_error  (rx_error),
    .sel       (sel),
    .latch_n   (latch_n),
    .sclk      (sclk),
    .sdo       (sdo),
    .valid     (valid),
    .violation (violation)
);

// File: tb/tb_cs_status_readout.sv
`timescale 1ns/1ps
module tb_cs_status_readout;
    localparam int FRAMES = 192;
    localparam int GAP    = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_locked = 1'b1, rx_error = 1'b0;
    logic frame_stb = 1'b0, blk_start = 1'b0, cs_bit = 1'b0;
    logic sel = 1'b0, latch_n = 1'b1, sclk = 1'b0;
    logic sdo, valid, violation;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cs_status_readout #(.CS_BITS(32), .FRAMES(FRAMES), .GAP_CYCLES(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .rx_locked(rx_locked), .rx_error(rx_error),
        .frame_stb(frame_stb), .blk_start(blk_start), .cs_bit(cs_bit),
        .sel(sel), .latch_n(latch_n), .sclk(sclk),
        .sdo(sdo), .valid(valid), .violation(violation)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // feeds one block; lock_gap_at >= 0 drops lock for one cycle before that frame
    task automatic feed_block(input logic [31:0] data, input logic lk,
                              input int lock_gap_at, input bit chk_pre);
        rx_locked = lk;
        for (int i = 0; i < FRAMES; i++) begin
            if (i == lock_gap_at) begin
                frame_stb = 1'b0; rx_locked = 1'b0; tick(); rx_locked = lk;
            end
            frame_stb = 1'b1;
            blk_start = (i == 0);
            cs_bit    = (i < 32) ? data[i] : i[0];
            if (chk_pre && i == FRAMES - 1) chk("R2 valid before last frame", valid, 1'b0);
            tick();
        end
        frame_stb = 1'b0; blk_start = 1'b0; cs_bit = 1'b0; rx_locked = 1'b1;
    endtask

    task automatic start_rd(input logic exp_viol);
        sel = 1'b1; latch_n = 1'b0;
        tick();
        chk("R4 marker bit", sdo, 1'b1);
        chk("R10 violation", violation, exp_viol);
        latch_n = 1'b1; sel = 1'b0;
        tick();
        chk("R10 violation single cycle", violation, 1'b0);
    endtask

    task automatic shift_chk(input string req, input logic exp);
        sclk = 1'b1; tick();
        chk(req, sdo, exp);
        sclk = 1'b0; tick();
    endtask

    task automatic read_all(input logic [31:0] exp);
        start_rd(1'b0);
        for (int k = 0; k < 32; k++) shift_chk("R5 data bit", exp[k]);
        shift_chk("R6 low after last bit", 1'b0);
        shift_chk("R6 stays low", 1'b0);
        idle(GAP + 20);
    endtask

    task automatic t_reset();
        chk("R1 sdo reset", sdo, 1'b0);
        chk("R1 valid reset", valid, 1'b0);
        chk("R1 violation reset", violation, 1'b0);
    endtask

    task automatic t_capture_read(input logic [31:0] d, input bit first);
        feed_block(d, 1'b1, -1, first);
        chk("R2 valid after block", valid, 1'b1);
        read_all(d);
    endtask

    task automatic t_sel_low();
        latch_n = 1'b0; tick();
        chk("R7 sdo with sel low", sdo, 1'b0);
        chk("R7 violation with sel low", violation, 1'b0);
        latch_n = 1'b1; tick();
        shift_chk("R7 no readout started", 1'b0);
        idle(GAP + 20);
    endtask

    task automatic t_violation();
        start_rd(1'b0);
        idle(20);
        start_rd(1'b1);
        idle(GAP + 50);
        start_rd(1'b0);
        idle(GAP + 20);
    endtask

    task automatic t_parity(input logic [31:0] d);
        start_rd(1'b0);
        for (int k = 0; k < 3; k++) shift_chk("R5 data bit", d[k]);
        rx_error = 1'b1; rx_locked = 1'b1; tick(); rx_error = 1'b0;
        chk("R9 sdo kept on parity error", sdo, d[2]);
        chk("R9 valid kept on parity error", valid, 1'b1);
        for (int k = 3; k < 32; k++) shift_chk("R9 stream intact", d[k]);
        idle(GAP + 20);
    endtask

    task automatic t_clear(input logic [31:0] d);
        start_rd(1'b0);
        for (int k = 0; k < 5; k++) shift_chk("R5 data bit", d[k]);
        rx_error = 1'b1; rx_locked = 1'b0; tick();
        rx_error = 1'b0; rx_locked = 1'b1;
        chk("R8 sdo cleared", sdo, 1'b0);
        chk("R8 valid cleared", valid, 1'b0);
        for (int k = 5; k < 32; k++) shift_chk("R8 remaining bits zero", 1'b0);
        idle(GAP + 20);
        read_all(32'h0);
    endtask

    task automatic t_unlocked();
        feed_block(32'hFFFF_FFFF, 1'b0, -1, 1'b0);
        chk("R3 unlocked block ignored", valid, 1'b0);
        feed_block(32'hFFFF_FFFF, 1'b1, 100, 1'b0);
        chk("R3 block with lock drop ignored", valid, 1'b0);
        read_all(32'h0);
    endtask

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_capture_read(32'hA5C3_0F96, 1'b1);
        t_capture_read(32'h1234_5678, 1'b0);
        t_sel_low();
        t_violation();
        t_parity(32'h1234_5678);
        t_clear(32'h1234_5678);
        t_unlocked();
        t_capture_read(32'h8000_0001, 1'b0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule